// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is the control engine of one DMA channel. It works through a linked list of buffer descriptors kept in memory. Each descriptor is four 32-bit words at consecutive word addresses: word 0 holds the address of the next descriptor, word 1 the buffer address, word 2 a control word and word 3 a status word. In the control word, bits 22:0 hold the byte length, bit 27 marks the start of a packet and bit 26 marks the end of a packet. For each descriptor the walker reads words 0 to 2 through a simple memory port and hands one transfer command to an external data mover. It then waits for the mover's done or error response and writes the status word back. In the status word, bit 31 means complete, bit 30 means error and bits 22:0 hold the transferred byte count.

Software programs a current-descriptor pointer while the channel is halted, writes a tail pointer and pulses run. The walker keeps going until the descriptor it has just finished sits at the tail address, and then it reports idle. Writing a new tail while idle makes it pick up again from the next pointer of the last finished descriptor. A pause stops the walk at the next descriptor boundary. Any error stops it as well and keeps it stopped until a soft reset. A length that is not a whole number of data words is an error on any descriptor except the tail.

Top module: `sgw_chain_walker`

## Requirements
- R1: After reset the channel is halted (halted_o=1, idle_o=0, err_o=0) and issues no memory access and no transfer command.
- R2: The transfer command carries word 1 as the address, control bits 22:0 as the length, control bit 27 as the start-of-packet flag and bit 26 as the end-of-packet flag. The command holds steady until the mover accepts it.
- R3: After a descriptor completes without error and is not the tail, the next descriptor is fetched from the address in its word 0.
- R4: On a good completion, the walker writes word 3 of the descriptor (byte offset 12) with bit 31 set, bit 30 clear and the mover's byte count in bits 22:0.
- R5: When the descriptor just completed has the tail pointer's address, the walker stops issuing work, cur_ptr_o stays on that descriptor and idle_o rises.
- R6: A tail write while halted is stored, but no descriptor is processed until run is pulsed.
- R7: A pause lets the transfer in flight finish and write its status, then the channel halts with cur_ptr_o on the following descriptor. A later run continues from there.
- R8: A descriptor that is not the tail, with a length that is not a multiple of WORD_BYTES, gets no command. Its status word is written as 0x40000000, err_o rises and the channel halts. Run pulses are ignored until a soft reset.
- R9: An error response from the mover is written to status as bit 30 set, bit 31 clear, plus the byte count. The channel then halts with err_o set and fetches nothing more.
- R10: pkt_done_o pulses for exactly one cycle for each good completion of a descriptor whose end-of-packet flag is set, and never for any other completion.
- R11: strm_ready_o is high exactly from the cycle after the mover accepts a command until the cycle in which its response is taken. It is low whenever no descriptor is in flight.
- R12: A tail write while idle resumes the walk at the next pointer of the last completed descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_ptr_we_i | input | 1 | Write strobe for the current-descriptor pointer (taken only when halted) |
| cur_ptr_wdata_i | input | AW | New current-descriptor pointer |
| tail_ptr_we_i | input | 1 | Write strobe for the tail pointer |
| tail_ptr_wdata_i | input | AW | New tail pointer |
| run_i | input | 1 | Start/resume pulse |
| pause_i | input | 1 | Pause pulse |
| sw_reset_i | input | 1 | Soft reset: halts and clears the error latch |
| halted_o | output | 1 | Channel halted at a descriptor boundary |
| idle_o | output | 1 | Running with no pending descriptors |
| err_o | output | 1 | Latched error |
| cur_ptr_o | output | AW | Current descriptor pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (status word) |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |
| cmd_valid_o | output | 1 | Transfer command valid |
| cmd_ready_i | input | 1 | Mover accepts command |
| cmd_addr_o | output | AW | Buffer address |
| cmd_len_o | output | LEN_W | Byte length |
| cmd_sop_o | output | 1 | Start-of-packet flag |
| cmd_eop_o | output | 1 | End-of-packet flag |
| rsp_valid_i | input | 1 | Mover response valid |
| rsp_err_i | input | 1 | Mover reports an error |
| rsp_bytes_i | input | LEN_W | Bytes actually moved |
| strm_ready_o | output | 1 | Stream input may accept data |
| pkt_done_o | output | 1 | One-cycle end-of-packet completion pulse |

## Verification
Most wrong internal states show up at the ports within one descriptor's time. A bad pointer shows as commands carrying the wrong buffer address or coming in the wrong order. A bad tail comparison shows as a command issued beyond the tail, or as idle_o never rising. A broken error latch shows as a command or memory read after err_o has risen, or as err_o dropping without a soft reset. The status words left in memory and the cycle-by-cycle match between strm_ready_o and the mover's outstanding transfer expose faults in completion handling right after the status write.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned DW            = 32;
  localparam int unsigned DESC_WORD_B   = 4;
  localparam int unsigned ST_WORD_IDX   = 3;
  localparam int unsigned ST_OFS        = ST_WORD_IDX * DESC_WORD_B;
  localparam int unsigned CTRL_SOP_BIT  = 27;
  localparam int unsigned CTRL_EOP_BIT  = 26;
  localparam int unsigned ST_DONE_BIT   = 31;
  localparam int unsigned ST_ERR_BIT    = 30;
  localparam int unsigned LAST_RD_IDX   = 2;

  typedef enum logic [2:0] {
    W_WAIT, W_RD_REQ, W_RD_CAP, W_CHECK, W_CMD, W_BUSY, W_WR_ST, W_NEXT
  } walk_st_t;

  // true when a byte length does not fill whole data words
  function automatic logic len_off_grid(input logic [31:0] len, input logic [31:0] wb);
    return (len % wb) != 32'd0;
  endfunction

  // status word built from completion outcome and moved byte count
  function automatic logic [DW-1:0] pack_status(input logic ok, input logic bad,
                                                input logic [31:0] cnt);
    logic [DW-1:0] w;
    w = cnt;
    w[ST_DONE_BIT] = ok;
    w[ST_ERR_BIT]  = bad;
    return w;
  endfunction
endpackage

// File: rtl/sgw_run_ctl.sv
module sgw_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic pause_i,
  input  logic sw_reset_i,
  input  logic fault_i,
  output logic run_o,
  output logic fault_latched_o
);
  logic run_q, flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      flt_q <= 1'b0;
    end else if (sw_reset_i) begin
      run_q <= 1'b0;
      flt_q <= 1'b0;
    end else if (fault_i) begin
      run_q <= 1'b0;
      flt_q <= 1'b1;
    end else if (pause_i) begin
      run_q <= 1'b0;
    end else if (run_i && !flt_q) begin
      run_q <= 1'b1;
    end
  end

  assign run_o           = run_q;
  assign fault_latched_o = flt_q;
endmodule

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
#(
  parameter int unsigned LEN_W      = 23,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [DW-1:0]    ctrl_word_i,
  input  logic             is_tail_i,
  output logic [LEN_W-1:0] len_o,
  output logic             sop_o,
  output logic             eop_o,
  output logic             len_bad_o
);
  localparam logic [31:0] WB = 32'(WORD_BYTES);

  assign len_o     = ctrl_word_i[LEN_W-1:0];
  assign sop_o     = ctrl_word_i[CTRL_SOP_BIT];
  assign eop_o     = ctrl_word_i[CTRL_EOP_BIT];
  assign len_bad_o = !is_tail_i && len_off_grid(32'(len_o), WB);
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned LEN_W      = 23,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_reset_i,
  input  logic             run_i,
  input  logic             cur_we_i,
  input  logic [AW-1:0]    cur_wdata_i,
  input  logic             tail_we_i,
  input  logic [AW-1:0]    tail_wdata_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [AW-1:0]    cmd_addr_o,
  output logic [LEN_W-1:0] cmd_len_o,
  output logic             cmd_sop_o,
  output logic             cmd_eop_o,
  input  logic             rsp_valid_i,
  input  logic             rsp_err_i,
  input  logic [LEN_W-1:0] rsp_bytes_i,
  output logic             at_rest_o,
  output logic             work_pend_o,
  output logic             fault_evt_o,
  output logic             pkt_done_o,
  output logic             strm_ready_o,
  output logic [AW-1:0]    cur_ptr_o
);
  walk_st_t         st_q;
  logic [AW-1:0]    cur_q, tail_q, next_q, buf_q;
  logic [DW-1:0]    ctrl_q;
  logic [1:0]       widx_q;
  logic             cur_done_q, work_pend_q, fin_err_q;
  logic [LEN_W-1:0] fin_bytes_q;

  logic             is_tail, len_bad, dec_sop, dec_eop;
  logic [LEN_W-1:0] dec_len;

  assign is_tail = (cur_q == tail_q);

  sgw_desc_decode #(.LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)) u_dec (
    .ctrl_word_i (ctrl_q),
    .is_tail_i   (is_tail),
    .len_o       (dec_len),
    .sop_o       (dec_sop),
    .eop_o       (dec_eop),
    .len_bad_o   (len_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= W_WAIT;
      cur_q       <= '0;
      tail_q      <= '0;
      next_q      <= '0;
      buf_q       <= '0;
      ctrl_q      <= '0;
      widx_q      <= '0;
      cur_done_q  <= 1'b0;
      work_pend_q <= 1'b0;
      fin_err_q   <= 1'b0;
      fin_bytes_q <= '0;
    end else begin
      case (st_q)
        W_WAIT: begin
          if (run_i && work_pend_q) begin
            if (cur_done_q) begin
              cur_q      <= next_q;
              cur_done_q <= 1'b0;
            end else begin
              widx_q <= '0;
              st_q   <= W_RD_REQ;
            end
          end
        end
        W_RD_REQ: st_q <= W_RD_CAP;
        W_RD_CAP: begin
          case (widx_q)
            2'd0:    next_q <= mem_rdata_i[AW-1:0];
            2'd1:    buf_q  <= mem_rdata_i[AW-1:0];
            default: ctrl_q <= mem_rdata_i;
          endcase
          if (widx_q == 2'(LAST_RD_IDX)) begin
            st_q <= W_CHECK;
          end else begin
            widx_q <= 2'(widx_q + 2'd1);
            st_q   <= W_RD_REQ;
          end
        end
        W_CHECK: begin
          if (len_bad) begin
            fin_err_q   <= 1'b1;
            fin_bytes_q <= '0;
            st_q        <= W_WR_ST;
          end else begin
            fin_err_q <= 1'b0;
            st_q      <= W_CMD;
          end
        end
        W_CMD: if (cmd_ready_i) st_q <= W_BUSY;
        W_BUSY: begin
          if (rsp_valid_i) begin
            fin_err_q   <= rsp_err_i;
            fin_bytes_q <= rsp_bytes_i;
            st_q        <= W_WR_ST;
          end
        end
        W_WR_ST: st_q <= W_NEXT;
        W_NEXT: begin
          st_q <= W_WAIT;
          if (fin_err_q || is_tail) begin
            cur_done_q <= 1'b1;
            if (!fin_err_q) work_pend_q <= 1'b0;
          end else begin
            cur_q <= next_q;
          end
        end
        default: st_q <= W_WAIT;
      endcase

      if (cur_we_i && !run_i && st_q == W_WAIT) begin
        cur_q      <= cur_wdata_i;
        cur_done_q <= 1'b0;
      end
      if (tail_we_i) begin
        tail_q      <= tail_wdata_i;
        work_pend_q <= 1'b1;
      end
      if (sw_reset_i) begin
        st_q      <= W_WAIT;
        fin_err_q <= 1'b0;
      end
    end
  end

  assign mem_req_o   = (st_q == W_RD_REQ) || (st_q == W_WR_ST);
  assign mem_we_o    = (st_q == W_WR_ST);
  assign mem_addr_o  = cur_q + ((st_q == W_WR_ST) ? AW'(ST_OFS) : AW'({widx_q, 2'b00}));
  assign mem_wdata_o = pack_status(!fin_err_q, fin_err_q, 32'(fin_bytes_q));

  assign cmd_valid_o = (st_q == W_CMD);
  assign cmd_addr_o  = buf_q;
  assign cmd_len_o   = dec_len;
  assign cmd_sop_o   = dec_sop;
  assign cmd_eop_o   = dec_eop;

  assign at_rest_o    = (st_q == W_WAIT);
  assign work_pend_o  = work_pend_q;
  assign fault_evt_o  = (st_q == W_NEXT) && fin_err_q;
  assign pkt_done_o   = (st_q == W_WR_ST) && !fin_err_q && dec_eop;
  assign strm_ready_o = (st_q == W_BUSY);
  assign cur_ptr_o    = cur_q;
endmodule

// File: rtl/sgw_chain_walker.sv
module sgw_chain_walker
  import sgw_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned LEN_W      = 23,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_ptr_we_i,
  input  logic [AW-1:0]    cur_ptr_wdata_i,
  input  logic             tail_ptr_we_i,
  input  logic [AW-1:0]    tail_ptr_wdata_i,
  input  logic             run_i,
  input  logic             pause_i,
  input  logic             sw_reset_i,
  output logic             halted_o,
  output logic             idle_o,
  output logic             err_o,
  output logic [AW-1:0]    cur_ptr_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [AW-1:0]    cmd_addr_o,
  output logic [LEN_W-1:0] cmd_len_o,
  output logic             cmd_sop_o,
  output logic             cmd_eop_o,
  input  logic             rsp_valid_i,
  input  logic             rsp_err_i,
  input  logic [LEN_W-1:0] rsp_bytes_i,
  output logic             strm_ready_o,
  output logic             pkt_done_o
);
  logic run_q, fault_evt, at_rest, work_pend;

  sgw_run_ctl u_run (
    .clk             (clk),
    .rst_n           (rst_n),
    .run_i           (run_i),
    .pause_i         (pause_i),
    .sw_reset_i      (sw_reset_i),
    .fault_i         (fault_evt),
    .run_o           (run_q),
    .fault_latched_o (err_o)
  );

  sgw_walker #(.AW(AW), .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_reset_i   (sw_reset_i),
    .run_i        (run_q),
    .cur_we_i     (cur_ptr_we_i),
    .cur_wdata_i  (cur_ptr_wdata_i),
    .tail_we_i    (tail_ptr_we_i),
    .tail_wdata_i (tail_ptr_wdata_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_len_o    (cmd_len_o),
    .cmd_sop_o    (cmd_sop_o),
    .cmd_eop_o    (cmd_eop_o),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_err_i    (rsp_err_i),
    .rsp_bytes_i  (rsp_bytes_i),
    .at_rest_o    (at_rest),
    .work_pend_o  (work_pend),
    .fault_evt_o  (fault_evt),
    .pkt_done_o   (pkt_done_o),
    .strm_ready_o (strm_ready_o),
    .cur_ptr_o    (cur_ptr_o)
  );

  assign halted_o = !run_q && at_rest;
  assign idle_o   = run_q && at_rest && !work_pend;
endmodule

// File: rtl/sgw_chain_walker_chk.sv
module sgw_chain_walker_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_reset_i,
  input logic          halted_o,
  input logic          idle_o,
  input logic          err_o,
  input logic          cmd_valid_o,
  input logic          cmd_ready_i,
  input logic [AW-1:0] cmd_addr_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          strm_ready_o,
  input logic          pkt_done_o,
  input logic          fault_evt,
  input logic          run_q
);
  a_r1_halt_idle_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted_o && idle_o));
  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o));
  a_r4_status_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> mem_addr_o[3:2] == 2'b11);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !mem_req_o && !cmd_valid_o);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !sw_reset_i |=> err_o);
  a_r8_err_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !cmd_valid_o);
  a_r9_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> !run_q && err_o);
  a_r10_pkt_single: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done_o |=> !pkt_done_o);
  a_r11_ready_excl_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    strm_ready_o |-> !cmd_valid_o);
endmodule

bind sgw_chain_walker sgw_chain_walker_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_reset_i   (sw_reset_i),
  .halted_o     (halted_o),
  .idle_o       (idle_o),
  .err_o        (err_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_addr_o   (cmd_addr_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .strm_ready_o (strm_ready_o),
  .pkt_done_o   (pkt_done_o),
  .fault_evt    (fault_evt),
  .run_q        (run_q)
);

// File: tb/sgw_chain_walker_tb_top.sv
module sgw_chain_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LEN_W = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             cur_we = 0, tail_we = 0, run = 0, pause = 0, srst = 0;
  logic [AW-1:0]    cur_wd = 0, tail_wd = 0;
  logic             halted, idle, err, mem_req, mem_we;
  logic [AW-1:0]    cur_ptr, mem_addr, cmd_addr;
  logic [31:0]      mem_wdata, mem_rdata;
  logic             cmd_valid, cmd_sop, cmd_eop, strm_ready, pkt_done;
  logic [LEN_W-1:0] cmd_len, rsp_bytes;
  logic             rsp_valid, rsp_err;

  sgw_chain_walker #(.AW(AW), .LEN_W(LEN_W), .WORD_BYTES(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cur_ptr_we_i(cur_we), .cur_ptr_wdata_i(cur_wd),
    .tail_ptr_we_i(tail_we), .tail_ptr_wdata_i(tail_wd),
    .run_i(run), .pause_i(pause), .sw_reset_i(srst),
    .halted_o(halted), .idle_o(idle), .err_o(err), .cur_ptr_o(cur_ptr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(1'b1), .cmd_addr_o(cmd_addr),
    .cmd_len_o(cmd_len), .cmd_sop_o(cmd_sop), .cmd_eop_o(cmd_eop),
    .rsp_valid_i(rsp_valid), .rsp_err_i(rsp_err), .rsp_bytes_i(rsp_bytes),
    .strm_ready_o(strm_ready), .pkt_done_o(pkt_done)
  );

  // descriptor memory, one-cycle read latency
  logic [31:0] mem [0:255];
  logic        mem_ops_seen;
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
  end
  always @(posedge clk) if (mem_req) mem_ops_seen <= 1'b1;

  // data mover model and command log
  logic [31:0]      log_addr [0:31];
  logic [LEN_W-1:0] log_len  [0:31];
  logic             log_sop  [0:31];
  logic             log_eop  [0:31];
  int               cmd_cnt = 0;
  int               err_at  = -1;
  int               pkt_cnt = 0;
  int               rdy_mismatch = 0;
  logic             mv_busy = 0;
  logic [1:0]       mv_cnt = 0;
  logic             mv_err = 0;

  initial begin
    rsp_valid = 0; rsp_err = 0; rsp_bytes = 0; mem_rdata = 0; mem_ops_seen = 0;
  end

  always @(posedge clk) begin
    if (rsp_valid) begin
      rsp_valid <= 1'b0;
      mv_busy   <= 1'b0;
    end else if (cmd_valid) begin
      log_addr[cmd_cnt[4:0]] <= cmd_addr;
      log_len[cmd_cnt[4:0]]  <= cmd_len;
      log_sop[cmd_cnt[4:0]]  <= cmd_sop;
      log_eop[cmd_cnt[4:0]]  <= cmd_eop;
      mv_err    <= (cmd_cnt == err_at);
      rsp_bytes <= cmd_len;
      cmd_cnt   <= cmd_cnt + 1;
      mv_busy   <= 1'b1;
      mv_cnt    <= 2'd3;
    end else if (mv_busy) begin
      if (mv_cnt == 0) begin
        rsp_valid <= 1'b1;
        rsp_err   <= mv_err;
      end else mv_cnt <= mv_cnt - 1;
    end
  end
  always @(posedge clk) if (pkt_done) pkt_cnt <= pkt_cnt + 1;
  always @(negedge clk) if (rst_n && (strm_ready !== mv_busy)) rdy_mismatch <= rdy_mismatch + 1;

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input int nxt, input int bufa, input int len,
                          input bit sop, input bit eop);
    mem[a/4]     = nxt;
    mem[a/4 + 1] = bufa;
    mem[a/4 + 2] = (32'(sop) << 27) | (32'(eop) << 26) | (len & 32'h7F_FFFF);
    mem[a/4 + 3] = 32'h0;
  endtask

  task automatic pulse_cur(input int v);
    @(negedge clk); cur_wd = v; cur_we = 1; @(negedge clk); cur_we = 0;
  endtask
  task automatic pulse_tail(input int v);
    @(negedge clk); tail_wd = v; tail_we = 1; @(negedge clk); tail_we = 0;
  endtask
  task automatic pulse_run();   @(negedge clk); run = 1;   @(negedge clk); run = 0;   endtask
  task automatic pulse_pause(); @(negedge clk); pause = 1; @(negedge clk); pause = 0; endtask
  task automatic pulse_srst();  @(negedge clk); srst = 1;  @(negedge clk); srst = 0;  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && !idle; i++) @(negedge clk);
  endtask
  task automatic wait_halted();
    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(halted == 1 && idle == 0 && err == 0, "R1 reset status", {halted, idle, err}, 3'b100);
    chk(cmd_cnt == 0 && !mem_ops_seen, "R1 no activity", cmd_cnt, 0);
  endtask

  task automatic t_chain3();
    put_desc('h100, 'h110, 'h1000, 64, 1, 0);
    put_desc('h110, 'h120, 'h2000, 32, 0, 0);
    put_desc('h120, 'h130, 'h3000, 10, 0, 1);
    pulse_cur('h100);
    pulse_tail('h120);
    repeat (20) @(negedge clk);
    chk(cmd_cnt == 0 && halted, "R6 tail write while halted", cmd_cnt, 0);
    pulse_run();
    wait_idle();
    chk(cmd_cnt == 3, "R5 stop at tail", cmd_cnt, 3);
    chk(log_addr[0] == 'h1000 && log_addr[1] == 'h2000 && log_addr[2] == 'h3000,
        "R3 next pointer order", log_addr[1], 'h2000);
    chk(log_len[0] == 64 && log_len[2] == 10, "R2 length field", log_len[2], 10);
    chk(log_sop[0] && !log_eop[0] && !log_sop[2] && log_eop[2], "R2 sop eop flags",
        {log_sop[0], log_eop[0], log_sop[2], log_eop[2]}, 4'b1001);
    chk(mem['h10C/4] == 32'h8000_0040, "R4 status first", mem['h10C/4], 32'h8000_0040);
    chk(mem['h12C/4] == 32'h8000_000A, "R4 status tail", mem['h12C/4], 32'h8000_000A);
    chk(pkt_cnt == 1, "R10 one packet", pkt_cnt, 1);
    chk(idle && !halted && cur_ptr == 'h120, "R5 idle at tail", cur_ptr, 'h120);
    repeat (10) @(negedge clk);
    chk(cmd_cnt == 3, "R5 no work past tail", cmd_cnt, 3);
  endtask

  task automatic t_extend();
    put_desc('h130, 'h100, 'h4000, 20, 1, 1);
    pulse_tail('h130);
    wait_idle();
    chk(cmd_cnt == 4 && log_addr[3] == 'h4000, "R12 resume from next", log_addr[3], 'h4000);
    chk(mem['h13C/4] == 32'h8000_0014 && cur_ptr == 'h130, "R12 status extended",
        mem['h13C/4], 32'h8000_0014);
    chk(pkt_cnt == 2, "R10 second packet", pkt_cnt, 2);
  endtask

  task automatic t_pause();
    pulse_pause();
    wait_halted();
    put_desc('h140, 'h150, 'h5000, 8, 1, 0);
    put_desc('h150, 'h160, 'h6000, 8, 0, 0);
    put_desc('h160, 'h140, 'h7000, 8, 0, 1);
    pulse_cur('h140);
    pulse_tail('h160);
    pulse_run();
    for (int i = 0; i < 100 && !strm_ready; i++) @(negedge clk);
    pulse_pause();
    wait_halted();
    chk(cmd_cnt == 5 && halted, "R7 pause after in-flight", cmd_cnt, 5);
    chk(cur_ptr == 'h150 && mem['h14C/4] == 32'h8000_0008, "R7 pointer retained",
        cur_ptr, 'h150);
    pulse_run();
    wait_idle();
    chk(cmd_cnt == 7 && log_addr[5] == 'h6000 && log_addr[6] == 'h7000, "R7 resume",
        log_addr[5], 'h6000);
    chk(pkt_cnt == 3, "R10 third packet", pkt_cnt, 3);
  endtask

  task automatic t_lenerr();
    pulse_pause();
    wait_halted();
    put_desc('h180, 'h190, 'h8000, 6, 1, 0);
    put_desc('h190, 'h180, 'h9000, 8, 0, 1);
    pulse_cur('h180);
    pulse_tail('h190);
    pulse_run();
    wait_halted();
    chk(err && halted && cmd_cnt == 7, "R8 length error halts", cmd_cnt, 7);
    chk(mem['h18C/4] == 32'h4000_0000, "R8 error status", mem['h18C/4], 32'h4000_0000);
    pulse_run();
    repeat (20) @(negedge clk);
    chk(err && halted && cmd_cnt == 7, "R8 run ignored while error", {err, halted}, 2'b11);
    pulse_srst();
    chk(!err && halted, "R8 soft reset clears", err, 0);
    mem['h188/4] = (32'd1 << 27) | 32'd8;
    pulse_cur('h180);
    pulse_tail('h190);
    pulse_run();
    wait_idle();
    chk(cmd_cnt == 9 && mem['h18C/4] == 32'h8000_0008, "R8 retry after reset", cmd_cnt, 9);
    chk(pkt_cnt == 4, "R10 fourth packet", pkt_cnt, 4);
  endtask

  task automatic t_mverr();
    pulse_pause();
    wait_halted();
    put_desc('h1A0, 'h1B0, 'hA000, 16, 1, 1);
    put_desc('h1B0, 'h1A0, 'hB000, 4, 1, 1);
    err_at = 9;
    pulse_cur('h1A0);
    pulse_tail('h1B0);
    pulse_run();
    wait_halted();
    chk(err && cmd_cnt == 10, "R9 mover error halts", cmd_cnt, 10);
    chk(mem['h1AC/4] == 32'h4000_0010, "R9 error status", mem['h1AC/4], 32'h4000_0010);
    chk(mem['h1BC/4] == 0 && pkt_cnt == 4, "R9 R10 nothing after error", pkt_cnt, 4);
    pulse_srst();
    chk(rdy_mismatch == 0, "R11 stream ready tracks transfer", rdy_mismatch, 0);
    chk(!strm_ready, "R11 ready low when nothing in flight", strm_ready, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    t_reset();
    t_chain3();
    t_extend();
    t_pause();
    t_lenerr();
    t_mverr();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule